// File: doc/BRIEF.md
# Power-Management Event and Sleep-Control Register Block

This block holds the power-management event state of a system: a 16-bit status register that records why the system woke, a 16-bit enable register that selects which of those causes may raise the system control interrupt, and a 16-bit control register through which software requests a sleep state. It is reached over a simple 32-bit memory-mapped request/response port. Reads return data one cycle after the request.

Wake causes arrive as single-cycle pulses from the real-time clock, the power-management timer and a catch-all source. Each pulse sets the shared wake flag together with that source's own flag. Software clears flags by writing ones. The interrupt output is a registered level. It is asserted when any status flag is matched by its enable bit, or when the auxiliary interrupt input from the general-purpose event logic is high.

A control write with the sleep-enable bit set decodes a 3-bit sleep type. Type 7 produces a one-cycle soft-off request. Types 5 and 6 produce a one-cycle pulse that flags an unsupported sleep state. The sleep-enable bit itself is never stored.

Top module: `pm1_evt_ctl`

## Requirements
- R1: After reset the status, enable and control registers read 0, and `sci_o`, `softoff_o`, `sleep_unsup_o`, `wake_en_rtc_o` and `wake_en_tmr_o` are 0.
- R2: Byte offset 0x0 reads status, 0x4 reads enable and 0x8 reads control, each zero-extended to 32 bits. Every other offset, including an unaligned one, reads 0, and writes to such an offset change no register.
- R3: Writing the status register clears each status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A `wake_rtc_i` pulse sets status bits 15 and 10. A `wake_tmr_i` pulse sets bits 15 and 0. A `wake_oth_i` pulse sets bits 15 and 8.
- R5: One cycle after the registers change, `sci_o` equals the OR over all bits of (status AND enable), ORed with `aux_sci_i` sampled in the same cycle.
- R6: `wake_en_rtc_o` follows enable bit 10 and `wake_en_tmr_o` follows enable bit 0, starting the cycle after the enable write.
- R7: A control write stores the low 16 bits of write data with bit 13 forced to 0.
- R8: When a control write has bit 13 set, bits 12:10 select the action. Value 7 pulses `softoff_o` for exactly one cycle. Values 5 and 6 pulse `sleep_unsup_o` for one cycle. Any other value, or bit 13 clear, pulses neither.
- R9: Only accesses with all four byte enables set (`req_be` = 4'b1111) take effect. Any other write is ignored, and any other read returns 0.
- R10: When a wake pulse and a status write that clears the same bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_be | input | DATA_W/8 | Byte enables |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | DATA_W | Read data |
| wake_rtc_i | input | 1 | Real-time-clock wake pulse |
| wake_tmr_i | input | 1 | PM-timer wake pulse |
| wake_oth_i | input | 1 | Other-cause wake pulse |
| aux_sci_i | input | 1 | Interrupt contribution from event/timer logic |
| sci_o | output | 1 | System control interrupt level |
| softoff_o | output | 1 | Soft-off request pulse |
| sleep_unsup_o | output | 1 | Unsupported sleep type pulse |
| wake_en_rtc_o | output | 1 | Clock wake enabled |
| wake_en_tmr_o | output | 1 | Timer wake enabled |

## Verification
A wake pulse and a write-one-to-clear of the same status bit can land in the same cycle. The bench provokes this by driving `wake_tmr_i` and a status write of 0x0001 on the same clock edge. It then judges the result by reading the status back, where bit 0 must remain set next to the flags that were set before. The bench also checks that the interrupt level, recomputed one cycle later, follows both the status change and the auxiliary input.

// File: rtl/pm1_pkg.sv
package pm1_pkg;
  localparam int unsigned REG_W       = 16;
  localparam int unsigned TMR_BIT     = 0;
  localparam int unsigned PWRBTN_BIT  = 8;
  localparam int unsigned RTC_BIT     = 10;
  localparam int unsigned SLP_EN_BIT  = 13;
  localparam int unsigned WAK_BIT     = 15;
  localparam int unsigned SLP_TYP_LSB = 10;
  localparam int unsigned SLP_TYP_W   = 3;
  localparam int unsigned NUM_WAKE    = 3;

  typedef enum logic [1:0] {RD_NONE, RD_STS, RD_EN, RD_CTL} rd_sel_e;
  typedef enum logic [1:0] {SLP_NOP, SLP_OFF, SLP_UNSUP} slp_act_e;

  // wake source index: 0 = clock, 1 = timer, 2 = other
  function automatic logic [REG_W-1:0] wake_mask(input int unsigned src);
    logic [REG_W-1:0] m;
    m = '0;
    m[WAK_BIT] = 1'b1;
    case (src)
      0:       m[RTC_BIT]    = 1'b1;
      1:       m[TMR_BIT]    = 1'b1;
      default: m[PWRBTN_BIT] = 1'b1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pm1_bus_decode.sv
module pm1_bus_decode #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned EVT_OFS = 0,
  parameter int unsigned CTL_OFS = 8
) (
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  wr_sts,
  output logic                  wr_en,
  output logic                  wr_ctl,
  output logic                  rd_req,
  output pm1_pkg::rd_sel_e      rd_sel
);
  import pm1_pkg::*;
  localparam int unsigned BE_W = DATA_W / 8;
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(EVT_OFS);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(EVT_OFS + 4);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_OFS);

  logic full_word;
  logic hit_sts, hit_en, hit_ctl;

  always_comb begin
    full_word = req_valid && (req_be == {BE_W{1'b1}});
    hit_sts   = full_word && (req_addr == A_STS);
    hit_en    = full_word && (req_addr == A_EN);
    hit_ctl   = full_word && (req_addr == A_CTL);
    wr_sts    = hit_sts && req_write;
    wr_en     = hit_en  && req_write;
    wr_ctl    = hit_ctl && req_write;
    rd_req    = req_valid && !req_write;
    if (!req_write && hit_sts)      rd_sel = RD_STS;
    else if (!req_write && hit_en)  rd_sel = RD_EN;
    else if (!req_write && hit_ctl) rd_sel = RD_CTL;
    else                            rd_sel = RD_NONE;
  end
endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_sts,
  input  logic                        wr_en,
  input  logic [pm1_pkg::REG_W-1:0]   wdata,
  input  logic                        wake_rtc,
  input  logic                        wake_tmr,
  input  logic                        wake_oth,
  output logic [pm1_pkg::REG_W-1:0]   sts_q,
  output logic [pm1_pkg::REG_W-1:0]   en_q
);
  import pm1_pkg::*;

  logic [NUM_WAKE-1:0] wake_vec;
  logic [REG_W-1:0]    set_part [NUM_WAKE];
  logic [REG_W-1:0]    set_all;
  logic [REG_W-1:0]    clr_mask;

  assign wake_vec = {wake_oth, wake_tmr, wake_rtc};

  for (genvar g = 0; g < NUM_WAKE; g++) begin : g_src
    assign set_part[g] = wake_vec[g] ? wake_mask(g) : '0;
  end

  always_comb begin
    set_all = '0;
    for (int i = 0; i < NUM_WAKE; i++) set_all = set_all | set_part[i];
    clr_mask = wr_sts ? wdata : '0;
  end

  // a new event takes priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_mask) | set_all;
      if (wr_en) en_q <= wdata;
    end
  end

  p_wake_rtc_r4: assert property (@(posedge clk) disable iff (rst)
    wake_rtc |=> (sts_q[WAK_BIT] && sts_q[RTC_BIT]));
  p_wake_tmr_r4: assert property (@(posedge clk) disable iff (rst)
    wake_tmr |=> (sts_q[WAK_BIT] && sts_q[TMR_BIT]));
  p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_sts && wdata[TMR_BIT] && !wake_tmr) |=> !sts_q[TMR_BIT]);
  p_race_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_sts && wdata[PWRBTN_BIT] && wake_oth) |=> sts_q[PWRBTN_BIT]);
  p_en_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/pm1_ctl_reg.sv
module pm1_ctl_reg (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_ctl,
  input  logic [pm1_pkg::REG_W-1:0]   wdata,
  output logic [pm1_pkg::REG_W-1:0]   ctl_q,
  output logic                        softoff_o,
  output logic                        unsup_o
);
  import pm1_pkg::*;
  localparam logic [REG_W-1:0] SLE_MASK = REG_W'(1) << SLP_EN_BIT;

  logic [SLP_TYP_W-1:0] typ;
  slp_act_e             act;

  always_comb begin
    typ = wdata[SLP_TYP_LSB +: SLP_TYP_W];
    act = SLP_NOP;
    if (wdata[SLP_EN_BIT]) begin
      case (typ)
        3'd7:       act = SLP_OFF;
        3'd5, 3'd6: act = SLP_UNSUP;
        default:    act = SLP_NOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      softoff_o <= 1'b0;
      unsup_o   <= 1'b0;
    end else begin
      softoff_o <= 1'b0;
      unsup_o   <= 1'b0;
      if (wr_ctl) begin
        ctl_q     <= wdata & ~SLE_MASK;
        softoff_o <= (act == SLP_OFF);
        unsup_o   <= (act == SLP_UNSUP);
      end
    end
  end

  p_store_r7: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> (ctl_q == ($past(wdata) & ~SLE_MASK)));
  p_off_cause_r8: assert property (@(posedge clk) disable iff (rst)
    softoff_o |-> $past(wr_ctl && wdata[SLP_EN_BIT] && (wdata[SLP_TYP_LSB +: SLP_TYP_W] == 3'd7)));
  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(softoff_o && unsup_o));
endmodule

// File: rtl/pm1_evt_ctl.sv
module pm1_evt_ctl #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned EVT_OFS = 0,
  parameter int unsigned CTL_OFS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic                wake_rtc_i,
  input  logic                wake_tmr_i,
  input  logic                wake_oth_i,
  input  logic                aux_sci_i,
  output logic                sci_o,
  output logic                softoff_o,
  output logic                sleep_unsup_o,
  output logic                wake_en_rtc_o,
  output logic                wake_en_tmr_o
);
  import pm1_pkg::*;

  logic             wr_sts, wr_en, wr_ctl, rd_req;
  rd_sel_e          rd_sel;
  logic [REG_W-1:0] sts_q, en_q, ctl_q;
  logic [DATA_W-1:0] rd_word;

  pm1_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_OFS(EVT_OFS), .CTL_OFS(CTL_OFS)
  ) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .wr_sts(wr_sts), .wr_en(wr_en), .wr_ctl(wr_ctl),
    .rd_req(rd_req), .rd_sel(rd_sel)
  );

  pm1_evt_regs u_evt (
    .clk(clk), .rst(rst), .wr_sts(wr_sts), .wr_en(wr_en),
    .wdata(req_wdata[REG_W-1:0]), .wake_rtc(wake_rtc_i),
    .wake_tmr(wake_tmr_i), .wake_oth(wake_oth_i),
    .sts_q(sts_q), .en_q(en_q)
  );

  pm1_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wdata(req_wdata[REG_W-1:0]),
    .ctl_q(ctl_q), .softoff_o(softoff_o), .unsup_o(sleep_unsup_o)
  );

  always_comb begin
    rd_word = '0;
    case (rd_sel)
      RD_STS:  rd_word[REG_W-1:0] = sts_q;
      RD_EN:   rd_word[REG_W-1:0] = en_q;
      RD_CTL:  rd_word[REG_W-1:0] = ctl_q;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      sci_o     <= 1'b0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_word;
      sci_o     <= (|(sts_q & en_q)) | aux_sci_i;
    end
  end

  assign wake_en_rtc_o = en_q[RTC_BIT];
  assign wake_en_tmr_o = en_q[TMR_BIT];

  p_sci_high_r5: assert property (@(posedge clk) disable iff (rst)
    (|(sts_q & en_q)) |=> sci_o);
  p_sci_low_r5: assert property (@(posedge clk) disable iff (rst)
    (!(|(sts_q & en_q)) && !aux_sci_i) |=> !sci_o);
  p_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);
endmodule

// File: tb/pm1_evt_ctl_tb.sv
module pm1_evt_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        wake_rtc_i = 1'b0, wake_tmr_i = 1'b0, wake_oth_i = 1'b0, aux_sci_i = 1'b0;
  logic        sci_o, softoff_o, sleep_unsup_o, wake_en_rtc_o, wake_en_tmr_o;

  int n_cmp = 0, n_bad = 0, n_off = 0, n_uns = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  pm1_evt_ctl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .wake_rtc_i(wake_rtc_i), .wake_tmr_i(wake_tmr_i), .wake_oth_i(wake_oth_i),
    .aux_sci_i(aux_sci_i), .sci_o(sci_o), .softoff_o(softoff_o),
    .sleep_unsup_o(sleep_unsup_o), .wake_en_rtc_o(wake_en_rtc_o),
    .wake_en_tmr_o(wake_en_tmr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data and counts output pulses
  always @(negedge clk) begin
    if (!rst) begin
      if (softoff_o) n_off++;
      if (sleep_unsup_o) n_uns++;
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk("R2 unexpected response", 32'h1, 32'h0);
        else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [3:0] be,
                        input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) wake_rtc_i = 1'b1;
    else if (which == 1) wake_tmr_i = 1'b1;
    else wake_oth_i = 1'b1;
    @(negedge clk);
    wake_rtc_i = 1'b0; wake_tmr_i = 1'b0; wake_oth_i = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 sci", {31'b0, sci_o}, 32'h0);
    chk("R1 wake_en", {30'b0, wake_en_rtc_o, wake_en_tmr_o}, 32'h0);
    bus_rd(8'h0, 4'hF, 32'h0, "R1 status");
    bus_rd(8'h4, 4'hF, 32'h0, "R1 enable");
    bus_rd(8'h8, 4'hF, 32'h0, "R1 control");

    // R6 / R2 enable write
    bus_wr(8'h4, 32'hABCD_0401, 4'hF);
    chk("R6 wake_en", {30'b0, wake_en_rtc_o, wake_en_tmr_o}, 32'h3);
    bus_rd(8'h4, 4'hF, 32'h0000_0401, "R2 enable readback");

    // R4 clock wake, R5 sci
    pulse(0);
    @(negedge clk);
    chk("R5 sci after clock wake", {31'b0, sci_o}, 32'h1);
    bus_rd(8'h0, 4'hF, 32'h0000_8400, "R4 clock wake");

    // R3 partial clear
    bus_wr(8'h0, 32'h0000_0400, 4'hF);
    @(negedge clk);
    chk("R5 sci after clear", {31'b0, sci_o}, 32'h0);
    bus_rd(8'h0, 4'hF, 32'h0000_8000, "R3 partial clear");

    // R4 timer wake
    pulse(1);
    @(negedge clk);
    chk("R5 sci after timer wake", {31'b0, sci_o}, 32'h1);
    bus_rd(8'h0, 4'hF, 32'h0000_8001, "R4 timer wake");
    bus_wr(8'h0, 32'hFFFF_FFFF, 4'hF);
    bus_rd(8'h0, 4'hF, 32'h0, "R3 clear all");

    // R4 other wake, R5 aux contribution
    pulse(2);
    @(negedge clk);
    chk("R5 sci masked", {31'b0, sci_o}, 32'h0);
    bus_rd(8'h0, 4'hF, 32'h0000_8100, "R4 other wake");
    @(negedge clk); aux_sci_i = 1'b1;
    @(negedge clk);
    chk("R5 sci from aux", {31'b0, sci_o}, 32'h1);
    aux_sci_i = 1'b0;
    @(negedge clk);
    chk("R5 sci aux released", {31'b0, sci_o}, 32'h0);

    // R10 wake and clear of the same bit in one cycle
    @(negedge clk);
    wake_tmr_i = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h0; req_wdata = 32'h0000_0001; req_be = 4'hF;
    @(negedge clk);
    wake_tmr_i = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    bus_rd(8'h0, 4'hF, 32'h0000_8101, "R10 set wins over clear");
    bus_wr(8'h0, 32'h0000_FFFF, 4'hF);

    // R2 unmapped offsets
    bus_wr(8'hC, 32'h0000_FFFF, 4'hF);
    bus_rd(8'hC, 4'hF, 32'h0, "R2 unmapped read");
    bus_rd(8'h2, 4'hF, 32'h0, "R2 unaligned read");
    bus_rd(8'h0, 4'hF, 32'h0, "R2 unmapped write no effect");

    // R9 partial byte enables
    bus_wr(8'h4, 32'h0000_FFFF, 4'h3);
    bus_rd(8'h4, 4'hF, 32'h0000_0401, "R9 partial write ignored");
    bus_rd(8'h4, 4'h1, 32'h0, "R9 partial read zero");
    bus_wr(8'h8, 32'h0000_3C00, 4'h7);
    chk("R9 no softoff on partial", n_off, 0);

    // R7 / R8 control
    bus_wr(8'h8, 32'h0000_2C05, 4'hF);
    bus_rd(8'h8, 4'hF, 32'h0000_0C05, "R7 sleep-enable stripped");
    chk("R8 type 3 no pulse", n_off + n_uns, 0);
    bus_wr(8'h8, 32'hFFFF_1234, 4'hF);
    bus_rd(8'h8, 4'hF, 32'h0000_1234, "R7 upper bits dropped");
    bus_wr(8'h8, 32'h0000_1C00, 4'hF);
    @(negedge clk);
    chk("R8 type 7 without enable", n_off, 0);
    bus_wr(8'h8, 32'h0000_3C00, 4'hF);
    @(negedge clk);
    chk("R8 soft-off single pulse", n_off, 1);
    bus_rd(8'h8, 4'hF, 32'h0000_1C00, "R7 stored after soft-off");
    bus_wr(8'h8, 32'h0000_3400, 4'hF);
    bus_wr(8'h8, 32'h0000_3800, 4'hF);
    @(negedge clk);
    chk("R8 unsupported pulses", n_uns, 2);
    chk("R8 no extra soft-off", n_off, 1);

    repeat (3) @(negedge clk);
    chk("R2 all reads answered", exp_q.size(), 0);
    finish_run();
  end
endmodule